// File: doc/BRIEF.md
# I2C Multi-Message Transfer Sequencer

This block sits on top of a byte-level I2C bit engine and walks through a list of messages for one combined transfer. Each message is described by a 7-bit target address, a direction flag, a byte count, a buffer base address and three option flags: tolerate a missing acknowledge, continue without a new START, and invert the direction bit sent on the wire. Software or another controller fills a small descriptor table. The sequencer selects descriptors by index. It pulses `go` with the message count and then waits for a completion pulse.

For every address or data byte, the sequencer hands one command to the bit engine. It then waits for the engine's per-byte completion event, which carries the acknowledge bit the engine sampled and any received byte. Transmit bytes are read from a synchronous byte buffer and received bytes are written back to it, at the message base plus a byte pointer that restarts at zero for every message. Before a START or transmit command is released, a fixed settling window gives the first data bit time to reach the line. The transfer ends with either a STOP or a plain release of the bus drivers, and the result reports the number of messages completed and a result code.

Top module: `i2c_msg_sequencer`

## Requirements
- R1: After reset, and at any time while no transfer is running, `engGo`, `bufWe`, `donePulse` and `evtArmed` are low. A completion event that arrives while idle has no effect on any output.
- R2: The first message, and every later message without the no-start flag, begins with an `engOp`=0 (START) command whose `engTx` is `{descAddr, descRead ^ descRevDir}`: the address occupies bits 7:1 and the direction bit is bit 0.
- R3: A not-acknowledge (`evtNak`=1) on an address byte ends the transfer with result code 1 (no device), unless that message's ignore-NAK flag is set.
- R4: Write data bytes go out as `engOp`=1 (XFER) commands in buffer order from `descBase` upward. A not-acknowledge on a data byte ends the transfer with result code 2 (refused), unless ignore-NAK is set for that message.
- R5: Each received byte is written to the buffer at `descBase` plus its index in the message. `engAck` is high on every read XFER command except the one for the last byte of the last message. An acknowledge bit reported for a read byte is ignored.
- R6: When the final message has length zero, the end command follows its address phase directly, and the result is success.
- R7: When a message ends and more follow, a next message without the no-start flag gets a new START. A no-start message with the same direction continues with data commands only. A no-start message whose direction differs from the last addressed message ends the transfer with result code 3 (invalid).
- R8: `engTx` holds its value for at least SETUP_CYC clock cycles before the cycle in which a START or write XFER command is issued.
- R9: `donePulse` is high for exactly one cycle per transfer, and `evtArmed` is low from the next cycle on. On success, `resultErr`=0 and `resultCount` equals `numMsgs`. In every case, `resultCount` is the number of messages fully finished.
- R10: The end command is issued in the `donePulse` cycle. It is `engOp`=2 (STOP) when `releaseMode` is low and `engOp`=3 (release drivers) when it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start a transfer (accepted while idle) |
| numMsgs | input | IDX_W+1 | Number of messages in the transfer (1..2^IDX_W) |
| releaseMode | input | 1 | End by releasing the drivers instead of STOP |
| msgIdx | output | IDX_W | Index of the descriptor being used |
| descAddr | input | 7 | Target address of the selected message |
| descRead | input | 1 | Selected message reads (1) or writes (0) |
| descLen | input | LEN_W | Byte count of the selected message |
| descBase | input | ADDR_W | Buffer base address of the selected message |
| descIgnNak | input | 1 | Tolerate not-acknowledge for the selected message |
| descNoStart | input | 1 | Continue the selected message without START |
| descRevDir | input | 1 | Invert the direction bit of the address byte |
| bufAddr | output | ADDR_W | Buffer byte address |
| bufWe | output | 1 | Buffer write strobe |
| bufWdata | output | 8 | Buffer write data |
| bufRdata | input | 8 | Buffer read data, one cycle after the address |
| engGo | output | 1 | Command strobe to the bit engine |
| engOp | output | 2 | 0 START+byte, 1 byte transfer, 2 STOP, 3 release |
| engTx | output | 8 | Byte to transmit |
| engAck | output | 1 | Acknowledge the byte being received |
| evtDone | input | 1 | Per-byte completion event from the engine |
| evtNak | input | 1 | Acknowledge bit sampled by the engine (1 = NAK) |
| rxByte | input | 8 | Byte received by the engine |
| evtArmed | output | 1 | Transfer in progress; events are expected |
| donePulse | output | 1 | One-cycle transfer completion |
| resultErr | output | 2 | 0 ok, 1 no device, 2 refused, 3 invalid |
| resultCount | output | IDX_W+1 | Messages completed |

## Verification
The assertions rely on the bit engine raising `evtDone` exactly once for each START or XFER command, never before the command, and only while `evtArmed` is high (apart from stray events while idle). They also assume that the descriptor table stays unchanged and that `go` arrives only while idle, with 1 to 2^IDX_W messages. The bench's engine model answers each command after a fixed latency and injects its only unsolicited event while the block is idle. The descriptor table is rewritten only between transfers, and not-acknowledge injection is restricted to one chosen event index per run.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  typedef enum logic [1:0] {
    OP_START   = 2'd0,
    OP_XFER    = 2'd1,
    OP_STOP    = 2'd2,
    OP_RELEASE = 2'd3
  } engOp_e;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_NODEV   = 2'd1,
    RES_REFUSED = 2'd2,
    RES_INVAL   = 2'd3
  } resCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic init;
    logic loadAddr;
    logic loadData;
    logic incPtr;
    logic nextMsg;
    logic bumpCount;
  } dpCtl_t;

endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import i2cseq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int LEN_W     = 4,
  parameter int IDX_W     = 3,
  parameter int SETUP_CYC = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [6:0]        descAddr,
  input  logic              descRead,
  input  logic              descRevDir,
  input  logic [LEN_W-1:0]  descLen,
  input  logic [ADDR_W-1:0] descBase,
  input  logic [IDX_W:0]    numMsgs,
  input  logic [7:0]        bufRdata,
  output logic [IDX_W-1:0]  msgIdx,
  output logic [ADDR_W-1:0] bufAddr,
  output logic [7:0]        txByte,
  output logic              atEnd,
  output logic              atLastByte,
  output logic              isLastMsg,
  output logic              setupDone,
  output logic [IDX_W:0]    doneCount
);

  localparam int SCW = $clog2(SETUP_CYC + 2);
  localparam logic [SCW-1:0] SETUP_LD = SCW'(SETUP_CYC);

  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] ptr;
  logic [IDX_W:0]   numReg;
  logic [IDX_W:0]   cnt;
  logic [7:0]       txReg;
  logic [SCW-1:0]   setupCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx      <= '0;
      ptr      <= '0;
      numReg   <= '0;
      cnt      <= '0;
      txReg    <= '0;
      setupCnt <= '0;
    end else begin
      if (ctl.init) begin
        idx    <= '0;
        ptr    <= '0;
        cnt    <= '0;
        numReg <= numMsgs;
      end
      if (ctl.nextMsg) begin
        idx <= idx + IDX_W'(1);
        ptr <= '0;
      end
      if (ctl.incPtr)    ptr <= ptr + LEN_W'(1);
      if (ctl.bumpCount) cnt <= cnt + (IDX_W+1)'(1);
      if (ctl.loadAddr) begin
        txReg    <= {descAddr, descRead ^ descRevDir};
        setupCnt <= SETUP_LD;
      end else if (ctl.loadData) begin
        txReg    <= bufRdata;
        setupCnt <= SETUP_LD;
      end else if (setupCnt != '0) begin
        setupCnt <= setupCnt - SCW'(1);
      end
    end
  end

  assign msgIdx     = idx;
  assign bufAddr    = descBase + ADDR_W'(ptr);
  assign txByte     = txReg;
  assign atEnd      = (ptr >= descLen);
  assign atLastByte = (descLen != '0) && (ptr == descLen - LEN_W'(1));
  assign isLastMsg  = (({1'b0, idx} + (IDX_W+1)'(1)) == numReg);
  assign setupDone  = (setupCnt == '0);
  assign doneCount  = cnt;

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= numReg);

endmodule

// File: rtl/seq_control.sv
module seq_control
  import i2cseq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     go,
  input  logic     releaseMode,
  input  logic     evtDone,
  input  logic     evtNak,
  input  logic     descIgnNak,
  input  logic     descNoStart,
  input  logic     descRead,
  input  logic     atEnd,
  input  logic     atLastByte,
  input  logic     isLastMsg,
  input  logic     setupDone,
  output dpCtl_t   ctl,
  output logic     engGo,
  output engOp_e   engOp,
  output logic     engAck,
  output logic     bufWe,
  output logic     donePulse,
  output logic     evtArmed,
  output resCode_e resultErr
);

  typedef enum logic [3:0] {
    S_IDLE, S_LAUNCH, S_SETTLE, S_START, S_DECIDE,
    S_FETCH, S_WRITE, S_READ, S_NEXT, S_STOP
  } state_e;

  state_e   state, nxt;
  logic     curRead, pendXfer, armed, setErr;
  resCode_e err, errNext;

  always_comb begin
    nxt       = state;
    ctl       = '0;
    engGo     = 1'b0;
    engOp     = OP_STOP;
    engAck    = 1'b0;
    bufWe     = 1'b0;
    donePulse = 1'b0;
    setErr    = 1'b0;
    errNext   = RES_OK;
    unique case (state)
      S_IDLE: if (go) begin
        ctl.init = 1'b1;
        nxt      = S_LAUNCH;
      end
      S_LAUNCH: begin
        ctl.loadAddr = 1'b1;
        nxt          = S_SETTLE;
      end
      S_SETTLE: if (setupDone) begin
        engGo = 1'b1;
        engOp = pendXfer ? OP_XFER : OP_START;
        nxt   = pendXfer ? S_WRITE : S_START;
      end
      S_START: if (evtDone) begin
        if (evtNak && !descIgnNak) begin
          setErr = 1'b1; errNext = RES_NODEV; nxt = S_STOP;
        end else nxt = S_DECIDE;
      end
      S_DECIDE: begin
        if (atEnd) begin
          ctl.bumpCount = 1'b1;
          if (isLastMsg) nxt = S_STOP;
          else begin
            ctl.nextMsg = 1'b1;
            nxt         = S_NEXT;
          end
        end else if (curRead) begin
          engGo  = 1'b1;
          engOp  = OP_XFER;
          engAck = !(atLastByte && isLastMsg);
          nxt    = S_READ;
        end else nxt = S_FETCH;
      end
      S_FETCH: begin
        ctl.loadData = 1'b1;
        ctl.incPtr   = 1'b1;
        nxt          = S_SETTLE;
      end
      S_WRITE: if (evtDone) begin
        if (evtNak && !descIgnNak) begin
          setErr = 1'b1; errNext = RES_REFUSED; nxt = S_STOP;
        end else nxt = S_DECIDE;
      end
      S_READ: if (evtDone) begin
        bufWe      = 1'b1;
        ctl.incPtr = 1'b1;
        nxt        = S_DECIDE;
      end
      S_NEXT: begin
        if (!descNoStart) nxt = S_LAUNCH;
        else if (descRead != curRead) begin
          setErr = 1'b1; errNext = RES_INVAL; nxt = S_STOP;
        end else nxt = S_DECIDE;
      end
      S_STOP: begin
        engGo     = 1'b1;
        engOp     = releaseMode ? OP_RELEASE : OP_STOP;
        donePulse = 1'b1;
        nxt       = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      curRead  <= 1'b0;
      pendXfer <= 1'b0;
      armed    <= 1'b0;
      err      <= RES_OK;
    end else begin
      state <= nxt;
      if (ctl.init) begin
        armed <= 1'b1;
        err   <= RES_OK;
      end
      if (state == S_LAUNCH) begin
        curRead  <= descRead;
        pendXfer <= 1'b0;
      end
      if (state == S_FETCH) pendXfer <= 1'b1;
      if (setErr) err <= errNext;
      if (donePulse) armed <= 1'b0;
    end
  end

  assign evtArmed  = armed;
  assign resultErr = err;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> (!engGo && !bufWe && !donePulse));

  // R5
  store_on_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> (evtDone && armed));

  // R9
  done_disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> (!armed && !donePulse));

  // R10
  end_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (engGo && (engOp == (releaseMode ? OP_RELEASE : OP_STOP))));

endmodule

// File: rtl/i2c_msg_sequencer.sv
module i2c_msg_sequencer
  import i2cseq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int LEN_W     = 4,
  parameter int IDX_W     = 3,
  parameter int SETUP_CYC = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              go,
  input  logic [IDX_W:0]    numMsgs,
  input  logic              releaseMode,
  output logic [IDX_W-1:0]  msgIdx,
  input  logic [6:0]        descAddr,
  input  logic              descRead,
  input  logic [LEN_W-1:0]  descLen,
  input  logic [ADDR_W-1:0] descBase,
  input  logic              descIgnNak,
  input  logic              descNoStart,
  input  logic              descRevDir,
  output logic [ADDR_W-1:0] bufAddr,
  output logic              bufWe,
  output logic [7:0]        bufWdata,
  input  logic [7:0]        bufRdata,
  output logic              engGo,
  output logic [1:0]        engOp,
  output logic [7:0]        engTx,
  output logic              engAck,
  input  logic              evtDone,
  input  logic              evtNak,
  input  logic [7:0]        rxByte,
  output logic              evtArmed,
  output logic              donePulse,
  output logic [1:0]        resultErr,
  output logic [IDX_W:0]    resultCount
);

  dpCtl_t   ctl;
  engOp_e   opE;
  resCode_e errE;
  logic     atEnd, atLastByte, isLastMsg, setupDone;

  seq_datapath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W), .SETUP_CYC(SETUP_CYC)
  ) u_dp (
    .clk, .rstN, .ctl, .descAddr, .descRead, .descRevDir, .descLen,
    .descBase, .numMsgs, .bufRdata, .msgIdx, .bufAddr, .txByte(engTx),
    .atEnd, .atLastByte, .isLastMsg, .setupDone, .doneCount(resultCount)
  );

  seq_control u_ctl (
    .clk, .rstN, .go, .releaseMode, .evtDone, .evtNak, .descIgnNak,
    .descNoStart, .descRead, .atEnd, .atLastByte, .isLastMsg, .setupDone,
    .ctl, .engGo, .engOp(opE), .engAck, .bufWe, .donePulse, .evtArmed,
    .resultErr(errE)
  );

  assign engOp     = opE;
  assign resultErr = errE;
  assign bufWdata  = rxByte;

  // observer of how long engTx has been held
  localparam int RCW = $clog2(SETUP_CYC + 2);
  logic [7:0]     lastTx;
  logic [RCW-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastTx <= '0;
      runCnt <= '0;
    end else begin
      lastTx <= engTx;
      if (engTx != lastTx)                 runCnt <= '0;
      else if (runCnt != RCW'(SETUP_CYC))  runCnt <= runCnt + RCW'(1);
    end
  end

  // R8
  settle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (engGo && opE == OP_START) |-> ((engTx == lastTx) && (int'(runCnt) + 1 >= SETUP_CYC)));

endmodule

// File: tb/test_i2c_msg_sequencer.sv
module test_i2c_msg_sequencer;

  localparam int SETUP = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       go = 1'b0;
  logic [3:0] numMsgs = '0;
  logic       releaseMode = 1'b0;
  logic [2:0] msgIdx;
  logic [6:0] descAddr;
  logic       descRead, descIgnNak, descNoStart, descRevDir;
  logic [3:0] descLen;
  logic [7:0] descBase, bufAddr, bufWdata, bufRdata, engTx, rxByte;
  logic       bufWe, engGo, engAck, evtDone, evtNak, evtArmed, donePulse;
  logic [1:0] engOp, resultErr;
  logic [3:0] resultCount;

  always #5 clk = ~clk;

  i2c_msg_sequencer i_i2c_msg_sequencer (
    .clk, .rstN, .go, .numMsgs, .releaseMode, .msgIdx, .descAddr, .descRead,
    .descLen, .descBase, .descIgnNak, .descNoStart, .descRevDir, .bufAddr,
    .bufWe, .bufWdata, .bufRdata, .engGo, .engOp, .engTx, .engAck, .evtDone,
    .evtNak, .rxByte, .evtArmed, .donePulse, .resultErr, .resultCount
  );

  // descriptor table
  logic [6:0] dAddr [8];
  logic       dRead [8], dIgn [8], dNoSt [8], dRev [8];
  logic [3:0] dLen  [8];
  logic [7:0] dBase [8];
  assign descAddr    = dAddr[msgIdx];
  assign descRead    = dRead[msgIdx];
  assign descLen     = dLen[msgIdx];
  assign descBase    = dBase[msgIdx];
  assign descIgnNak  = dIgn[msgIdx];
  assign descNoStart = dNoSt[msgIdx];
  assign descRevDir  = dRev[msgIdx];

  function automatic logic [7:0] memInit(int a);
    return 8'(a * 5 + 3);
  endfunction
  function automatic logic [7:0] rxPat(int e);
    return 8'(e * 37 + 92);
  endfunction

  // buffer, engine model and log
  logic [7:0] mem [256];
  logic       clearReq = 1'b0, strayReq = 1'b0;
  int         nakAt = -1;
  int         evIdx, latCnt, logN, runLen;
  logic [7:0] lastTx;
  int         opLog [64], txLog [64], ackLog [64], stLog [64];

  always @(posedge clk) begin
    int nr;
    bufRdata <= mem[bufAddr];
    if (clearReq) begin
      for (int a = 0; a < 256; a++) mem[a] <= memInit(a);
    end else if (bufWe) mem[bufAddr] <= bufWdata;
    nr = (engTx == lastTx) ? runLen + 1 : 1;
    runLen <= nr;
    lastTx <= engTx;
    evtDone <= 1'b0;
    if (clearReq) begin
      logN <= 0; evIdx <= 0; latCnt <= 0; evtNak <= 1'b0; rxByte <= '0;
    end else begin
      if (strayReq) begin
        evtDone <= 1'b1; evtNak <= 1'b0; rxByte <= 8'hEE;
      end
      if (latCnt != 0) begin
        if (latCnt == 1) begin
          evtDone <= 1'b1;
          evtNak  <= (evIdx == nakAt);
          rxByte  <= rxPat(evIdx);
          evIdx   <= evIdx + 1;
        end
        latCnt <= latCnt - 1;
      end
      if (engGo && logN < 64) begin
        opLog[logN]  <= int'(engOp);
        txLog[logN]  <= int'(engTx);
        ackLog[logN] <= int'(engAck);
        stLog[logN]  <= nr - 1;
        logN <= logN + 1;
        if (engOp == 2'd0 || engOp == 2'd1) latCnt <= 3;
      end
    end
  end

  int checks = 0, errors = 0;

  task automatic chkEq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // expected trace
  int         eOp [64], eTx [64], eAck [64], eKind [64];  // kind 0 start,1 wr,2 rd,3 end
  int         eN, eErr, eCnt;
  logic [7:0] expMem [256];

  task automatic push(input int op, input int tx, input int ack, input int kind);
    if (eN < 64) begin
      eOp[eN] = op; eTx[eN] = tx; eAck[eN] = ack; eKind[eN] = kind;
    end
    eN++;
  endtask

  task automatic predict(input int n, input int nk, input bit rel);
    int ev = 0;
    bit stop = 0;
    eN = 0; eErr = 0; eCnt = 0;
    for (int a = 0; a < 256; a++) expMem[a] = memInit(a);
    for (int i = 0; i < n && !stop; i++) begin
      if (i == 0 || !dNoSt[i]) begin
        push(0, int'({dAddr[i], dRead[i] ^ dRev[i]}), 0, 0);
        if (ev == nk && !dIgn[i]) begin eErr = 1; stop = 1; end
        ev++;
      end else if (dRead[i] != dRead[i-1]) begin
        eErr = 3; stop = 1;
      end
      for (int p = 0; p < int'(dLen[i]) && !stop; p++) begin
        if (dRead[i]) begin
          push(1, 0, (p == int'(dLen[i]) - 1 && i == n - 1) ? 0 : 1, 2);
          expMem[8'(int'(dBase[i]) + p)] = rxPat(ev);
          ev++;
        end else begin
          push(1, int'(memInit(int'(8'(int'(dBase[i]) + p)))), 0, 1);
          if (ev == nk && !dIgn[i]) begin eErr = 2; stop = 1; end
          ev++;
        end
      end
      if (!stop) eCnt++;
    end
    push(rel ? 3 : 2, 0, 0, 3);
  endtask

  task automatic setMsg(input int i, input int addr, input bit rd, input int len,
                        input int base, input bit ign, input bit nost, input bit rev);
    dAddr[i] = 7'(addr); dRead[i] = rd; dLen[i] = 4'(len); dBase[i] = 8'(base);
    dIgn[i] = ign; dNoSt[i] = nost; dRev[i] = rev;
  endtask

  task automatic runScn(input int n, input int nk, input bit rel, input bit probe);
    int t = 0;
    int gotErr, gotCnt, bad;
    string rtag, ktag;
    predict(n, nk, rel);
    nakAt = nk;
    @(negedge clk) clearReq = 1'b1;
    @(negedge clk) clearReq = 1'b0;
    numMsgs = 4'(n); releaseMode = rel; go = 1'b1;
    @(negedge clk) go = 1'b0;
    while (!donePulse && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (!donePulse) begin
      checks++; errors++;
      $display("FAIL R9 transfer timeout actual=0 expected=1");
      return;
    end
    gotErr = int'(resultErr); gotCnt = int'(resultCount);
    @(negedge clk);
    chkEq("R9", "armed after done", int'(evtArmed), 0);
    chkEq("R9", "done pulse width", int'(donePulse), 0);
    repeat (2) @(negedge clk);
    case (eErr)
      1: rtag = "R3";
      2: rtag = "R4";
      3: rtag = "R7";
      default: rtag = probe ? "R6" : "R9";
    endcase
    chkEq(rtag, "result code", gotErr, eErr);
    chkEq(rtag, "result count", gotCnt, eCnt);
    chkEq("R7", "command count", logN, eN);
    for (int j = 0; j < eN && j < logN && j < 64; j++) begin
      case (eKind[j])
        0: ktag = "R2";
        1: ktag = "R4";
        2: ktag = "R5";
        default: ktag = "R10";
      endcase
      chkEq(ktag, "command op", opLog[j], eOp[j]);
      if (eKind[j] == 0 || eKind[j] == 1) begin
        chkEq(ktag, "tx byte", txLog[j], eTx[j]);
        chkEq("R8", "tx settle ok", int'(stLog[j] >= SETUP), 1);
      end
      if (eKind[j] == 2) chkEq("R5", "ack enable", ackLog[j], eAck[j]);
    end
    bad = 0;
    for (int a = 0; a < 256; a++) if (mem[a] !== expMem[a]) bad++;
    chkEq("R5", "buffer mismatches", bad, 0);
  endtask

  initial begin
    int quiet;
    for (int i = 0; i < 8; i++) setMsg(i, 0, 0, 0, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R1", "reset engGo", int'(engGo), 0);
    chkEq("R1", "reset armed", int'(evtArmed), 0);
    chkEq("R1", "reset done", int'(donePulse), 0);
    chkEq("R1", "reset bufWe", int'(bufWe), 0);

    // stray event while idle
    quiet = 1;
    @(negedge clk) strayReq = 1'b1;
    @(negedge clk) strayReq = 1'b0;
    repeat (6) begin
      @(negedge clk);
      if (engGo || donePulse || evtArmed || bufWe) quiet = 0;
    end
    chkEq("R1", "idle event ignored", quiet, 1);

    // single writes: length, address and direction-invert sweep
    for (int len = 0; len < 4; len++)
      for (int ai = 0; ai < 3; ai++)
        for (int rv = 0; rv < 2; rv++) begin
          setMsg(0, (ai == 0) ? 0 : (ai == 1) ? 'h5A : 'h7F, 0, len, 'h10, 0, 0, rv[0]);
          runScn(1, -1, 0, len == 0);
        end

    // single reads
    for (int len = 0; len < 4; len++)
      for (int rv = 0; rv < 2; rv++) begin
        setMsg(0, 'h33, 1, len, 'h40, 0, 0, rv[0]);
        runScn(1, -1, 0, len == 0);
      end

    // not-acknowledge sweep over every event of write(2)+read(2)
    for (int ig = 0; ig < 2; ig++)
      for (int nk = 0; nk < 6; nk++) begin
        setMsg(0, 'h21, 0, 2, 'h10, ig[0], 0, 0);
        setMsg(1, 'h22, 1, 2, 'h60, ig[0], 0, 0);
        runScn(2, nk, 0, 0);
      end

    // chaining cases, both end modes
    for (int rl = 0; rl < 2; rl++) begin
      setMsg(0, 'h11, 0, 2, 'h10, 0, 0, 0);
      setMsg(1, 'h11, 0, 2, 'h20, 0, 1, 0);
      runScn(2, -1, rl[0], 0);
      setMsg(0, 'h12, 0, 1, 'h10, 0, 0, 0);
      setMsg(1, 'h12, 1, 1, 'h50, 0, 1, 0);
      runScn(2, -1, rl[0], 0);
      setMsg(0, 'h13, 1, 2, 'h50, 0, 0, 0);
      setMsg(1, 'h13, 1, 1, 'h58, 0, 1, 0);
      runScn(2, -1, rl[0], 0);
      setMsg(0, 'h14, 1, 1, 'h50, 0, 0, 1);
      setMsg(1, 'h15, 0, 1, 'h30, 0, 0, 0);
      setMsg(2, 'h16, 0, 0, 'h30, 0, 0, 0);
      runScn(3, -1, rl[0], 1);
      setMsg(0, 'h17, 0, 3, 'h10, 0, 0, 0);
      setMsg(1, 'h17, 0, 0, 'h20, 0, 1, 0);
      setMsg(2, 'h18, 1, 2, 'h70, 0, 0, 0);
      setMsg(3, 'h18, 1, 2, 'h78, 0, 1, 0);
      runScn(4, -1, rl[0], 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule